// File: doc/BRIEF.md
# Flash Read Wait-State Controller

This block sits between a simple bus read port and an on-chip nonvolatile data array whose access time is longer than one bus clock. Each read is stretched by a programmable number of wait cycles, so a slow array can serve a fast bus. The bus holds `rd_req` and `rd_addr` steady until the block answers with a one-cycle `rd_ready` pulse carrying `rd_data`. That pulse is the only flow-control signal. `rd_ready` stays low for the whole stretch, and a request still asserted in the cycle after the pulse is a new access.

The wait count lives in a 3-bit field of a configuration register. The register can only be changed through a guarded path. First, two mode writes in a row put the block into a timing-configuration mode. Then a configuration write must carry a 16-bit key in its upper half. Writes with a bad key, or writes made outside the mode, leave the count unchanged. The array itself is combinational from the block's point of view: the block drives `arr_addr` and passes `arr_rdata` through on the ready cycle.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the wait field reads back as 5, the mode readback bit (bit 0 with `reg_sel`=0) is 0, and `rd_ready` is low while no request is present.
- R2: With effective wait W, a request first seen in cycle c gets `rd_ready` high in cycle c+W only, for exactly one cycle. The read therefore takes W+1 cycles, and `rd_ready` is low in the cycles before.
- R3: During an access `arr_addr` equals the address the request presented. `rd_data` equals `arr_rdata` in the ready cycle and is zero in all other cycles.
- R4: A mode write (`reg_sel`=0) of 0x81 followed directly by a mode write of 0x28 enters timing-configuration mode, shown as readback bit 0 = 1. Repeating 0x81 before the 0x28 still counts as the first step.
- R5: A 0x28 that does not come directly after a 0x81, or any other value that breaks the pair, does not enter the mode.
- R6: A mode write of zero leaves timing-configuration mode. Other mode writes made while in the mode leave it in place.
- R7: A configuration write (`reg_sel`=1) made in timing-configuration mode with bits 31:16 equal to 0x7858 loads bits 10:8 into the wait field. With `reg_sel`=1 the field reads back at bits 10:8.
- R8: A configuration write with a wrong key, or one made outside timing-configuration mode, is ignored, and the previous wait value is kept.
- R9: Stored wait values 6 and 7 both give an effective wait of 6, i.e. 7-cycle reads. Readback shows the stored value.
- R10: A wait value written during an access does not change that access. It applies from the next request.
- R11: With `rd_req` held high, accesses follow each other with no idle cycle: one pulse every W+1 cycles, and one pulse every cycle when W is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 13 | Read word address, held with `rd_req` |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read data, valid with `rd_ready` |
| arr_addr | output | 13 | Address to the array |
| arr_rdata | input | 32 | Data from the array |

## Verification
`rd_ready` and `rd_data` are due W cycles after the cycle in which the request is first presented. They are combinational in that cycle when W is 0. A register write is due in readback and in the effective wait one edge after its strobe. The bench drives inputs on the falling edge and compares every output a fixed delay later, still before the next rising edge, against a behavioural model advanced on each rising edge. Directed read tasks count the cycles from the request to the pulse, and check that count against W+1 for each wait setting, including a write made in the middle of an access.

// File: rtl/fwc_pkg.sv
`timescale 1ns/1ps
package fwc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_TIMING = 2'd2
  } fwc_mode_e;
endpackage

// File: rtl/fwc_unlock.sv
`timescale 1ns/1ps
module fwc_unlock import fwc_pkg::*; #(
  parameter int          DATA_W = 32,
  parameter logic [7:0]  CODE_A = 8'h81,
  parameter logic [7:0]  CODE_B = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              timing_o
);
  fwc_mode_e state_q, state_d;
  logic is_zero, is_a, is_b;

  assign is_zero = (wdata_i == '0);
  assign is_a    = (wdata_i == DATA_W'(CODE_A));
  assign is_b    = (wdata_i == DATA_W'(CODE_B));

  always_comb begin
    state_d = state_q;
    if (wr_en_i) begin
      if (is_zero) state_d = MODE_NORMAL;
      else begin
        case (state_q)
          MODE_NORMAL: state_d = is_a ? MODE_HALF : MODE_NORMAL;
          MODE_HALF:   state_d = is_b ? MODE_TIMING : (is_a ? MODE_HALF : MODE_NORMAL);
          MODE_TIMING: state_d = MODE_TIMING;
          default:     state_d = MODE_NORMAL;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_NORMAL;
    else        state_q <= state_d;
  end

  assign timing_o = (state_q == MODE_TIMING);

  AST_EXIT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wdata_i == '0) |=> (state_q == MODE_NORMAL)); // R6
  AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timing_o) |-> $past(state_q == MODE_HALF)); // R4
endmodule

// File: rtl/fwc_cfg_reg.sv
`timescale 1ns/1ps
module fwc_cfg_reg #(
  parameter int                 DATA_W   = 32,
  parameter int                 WAIT_W   = 3,
  parameter int                 WAIT_LSB = 8,
  parameter int                 KEY_W    = 16,
  parameter logic [KEY_W-1:0]   KEY      = 16'h7858,
  parameter int                 WAIT_RST = 5,
  parameter int                 WAIT_CAP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              timing_i,
  output logic [WAIT_W-1:0] wait_raw_o,
  output logic [WAIT_W-1:0] wait_eff_o
);
  localparam logic [WAIT_W-1:0] CAP_V = WAIT_W'(WAIT_CAP);
  localparam logic [WAIT_W-1:0] RST_V = WAIT_W'(WAIT_RST);

  logic [WAIT_W-1:0] wait_q;
  logic              key_ok, load;
  logic              unused_wdata;

  assign key_ok       = (wdata_i[DATA_W-1 -: KEY_W] == KEY);
  assign load         = wr_en_i && timing_i && key_ok;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wait_q <= RST_V;
    else if (load) wait_q <= wdata_i[WAIT_LSB +: WAIT_W];
  end

  assign wait_raw_o = wait_q;
  assign wait_eff_o = (wait_q > CAP_V) ? CAP_V : wait_q;

  AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wait_q) |-> $past(wr_en_i && timing_i && key_ok)); // R8
  AST_EFF_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wait_eff_o <= CAP_V); // R9
endmodule

// File: rtl/fwc_wait_seq.sv
`timescale 1ns/1ps
module fwc_wait_seq #(
  parameter int ADDR_W   = 13,
  parameter int WAIT_W   = 3,
  parameter int WAIT_CAP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WAIT_W-1:0] wait_eff_i,
  output logic              ready_o,
  output logic [ADDR_W-1:0] arr_addr_o
);
  logic              busy_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start;

  assign start      = !busy_q && rd_req_i && (wait_eff_i != '0);
  assign ready_o    = busy_q ? (cnt_q == '0) : (rd_req_i && wait_eff_i == '0);
  assign arr_addr_o = busy_q ? addr_q : rd_addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_eff_i - 1'b1;
      addr_q <= rd_addr_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < WAIT_W'(WAIT_CAP))); // R9
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_o) |=> !busy_q); // R2
  AST_CNT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (cnt_q == WAIT_W'($past(cnt_q) - 1'b1))); // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(arr_addr_o)); // R3
endmodule

// File: rtl/flash_wait_ctrl.sv
`timescale 1ns/1ps
module flash_wait_ctrl #(
  parameter int          ADDR_W   = 13,
  parameter int          DATA_W   = 32,
  parameter int          WAIT_W   = 3,
  parameter int          WAIT_LSB = 8,
  parameter int          KEY_W    = 16,
  parameter logic [15:0] KEY      = 16'h7858,
  parameter int          WAIT_RST = 5,
  parameter int          WAIT_CAP = 6,
  parameter logic [7:0]  CODE_A   = 8'h81,
  parameter logic [7:0]  CODE_B   = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata
);
  logic              timing;
  logic [WAIT_W-1:0] wait_raw, wait_eff;
  logic [DATA_W-1:0] cfg_word, mode_word;

  fwc_unlock #(.DATA_W(DATA_W), .CODE_A(CODE_A), .CODE_B(CODE_B)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr && !reg_sel),
    .wdata_i(reg_wdata), .timing_o(timing));

  fwc_cfg_reg #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .WAIT_LSB(WAIT_LSB),
                .KEY_W(KEY_W), .KEY(KEY[KEY_W-1:0]), .WAIT_RST(WAIT_RST),
                .WAIT_CAP(WAIT_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr && reg_sel),
    .wdata_i(reg_wdata), .timing_i(timing),
    .wait_raw_o(wait_raw), .wait_eff_o(wait_eff));

  fwc_wait_seq #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .WAIT_CAP(WAIT_CAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .wait_eff_i(wait_eff), .ready_o(rd_ready), .arr_addr_o(arr_addr));

  always_comb begin
    cfg_word = '0;
    cfg_word[WAIT_LSB +: WAIT_W] = wait_raw;
    mode_word = '0;
    mode_word[0] = timing;
  end

  assign reg_rdata = reg_sel ? cfg_word : mode_word;
  assign rd_data   = rd_ready ? arr_rdata : '0;

  AST_NO_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_req && !$past(rd_req)) |-> !rd_ready); // R2
endmodule

// File: tb/tb_flash_wait_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wait_ctrl;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0, rd_req = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, rd_data, arr_rdata;
  logic [12:0] rd_addr = 0, arr_addr;
  logic rd_ready;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  flash_wait_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .arr_addr(arr_addr), .arr_rdata(arr_rdata));

  function automatic logic [31:0] arr_fn(logic [12:0] a);
    return {a ^ 13'h1555, 6'h2A, a};
  endfunction
  assign arr_rdata = arr_fn(arr_addr);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode = 0, m_wait = 5, m_left = 0;
  bit m_busy = 0;
  logic [12:0] m_addr = 0;
  function automatic int eff(int w); return (w > 6) ? 6 : w; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_wait = 5; m_busy = 0; m_left = 0;
    end else begin
      if (m_busy) begin
        if (m_left == 0) m_busy = 0; else m_left--;
      end else if (rd_req && eff(m_wait) > 0) begin
        m_busy = 1; m_left = eff(m_wait) - 1; m_addr = rd_addr;
      end
      if (reg_wr && reg_sel && m_mode == 2 && reg_wdata[31:16] == 16'h7858)
        m_wait = int'(reg_wdata[10:8]);
      if (reg_wr && !reg_sel) begin
        if (reg_wdata == 0) m_mode = 0;
        else if (m_mode == 0) m_mode = (reg_wdata == 32'h81) ? 1 : 0;
        else if (m_mode == 1) m_mode = (reg_wdata == 32'h28) ? 2 :
                                       ((reg_wdata == 32'h81) ? 1 : 0);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic e_rdy; logic [12:0] e_a; logic [31:0] e_rd;
      e_rdy = m_busy ? (m_left == 0) : (rd_req && eff(m_wait) == 0);
      e_a   = m_busy ? m_addr : rd_addr;
      e_rd  = reg_sel ? {21'h0, 3'(m_wait), 8'h0} : {31'h0, m_mode == 2};
      chk(rd_ready === e_rdy, "R2 ready", {31'h0, rd_ready}, {31'h0, e_rdy});
      chk(rd_data === (e_rdy ? arr_fn(e_a) : 32'h0), "R3 data", rd_data,
          e_rdy ? arr_fn(e_a) : 32'h0);
      if (rd_req || m_busy) chk(arr_addr === e_a, "R3 addr", {19'h0, arr_addr}, {19'h0, e_a});
      chk(reg_rdata === e_rd, "R7 readback", reg_rdata, e_rd);
    end
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rb(bit sel, logic [31:0] exp, string tag);
    @(negedge clk); reg_sel = sel; #3;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic do_read(logic [12:0] a, int exp_n, string tag, int mid_cyc, logic [31:0] mid_d);
    int n = 1;
    @(negedge clk); rd_req = 1; rd_addr = a;
    forever begin
      if (n == mid_cyc) begin reg_wr = 1; reg_sel = 1; reg_wdata = mid_d; end
      else reg_wr = 0;
      #3;
      if (rd_ready || n > 20) break;
      @(negedge clk); n++;
    end
    chk(n == exp_n, tag, n, exp_n);
    chk(rd_data === arr_fn(a), "R3 read data", rd_data, arr_fn(a));
    @(negedge clk); rd_req = 0; reg_wr = 0;
  endtask

  task automatic stream(int cyc, int exp_pulses, string tag);
    int p = 0;
    @(negedge clk); rd_req = 1; rd_addr = 13'h0AB;
    for (int i = 0; i < cyc; i++) begin
      #3; if (rd_ready) p++;
      @(negedge clk);
    end
    rd_req = 0;
    chk(p == exp_pulses, tag, p, exp_pulses);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; chk(rd_ready === 1'b0, "R1 ready low", {31'h0, rd_ready}, 0);
    rst_n = 1;
    rb(1, 32'h500, "R1 wait reset 5");
    rb(0, 32'h0, "R1 mode reset");
    do_read(13'h011, 6, "R2 latency W=5", 0, 0);
    wr(1, 32'h7858_0300);
    rb(1, 32'h500, "R8 outside mode ignored");
    wr(0, 32'h81); wr(0, 32'h28);
    rb(0, 32'h1, "R4 unlock");
    wr(1, 32'h1234_0300);
    rb(1, 32'h500, "R8 wrong key ignored");
    wr(1, 32'h7858_0300);
    rb(1, 32'h300, "R7 key load 3");
    do_read(13'h1F0, 4, "R2 latency W=3", 0, 0);
    wr(0, 32'h55);
    rb(0, 32'h1, "R6 nonzero write stays");
    wr(1, 32'h7858_0000);
    do_read(13'h002, 1, "R2 latency W=0", 0, 0);
    stream(6, 6, "R11 stream W=0");
    wr(1, 32'h7858_0100);
    stream(8, 4, "R11 stream W=1");
    wr(1, 32'h7858_0700);
    rb(1, 32'h700, "R9 readback 7");
    do_read(13'h0C3, 7, "R9 latency W=7", 0, 0);
    wr(1, 32'h7858_0600);
    do_read(13'h0C4, 7, "R9 latency W=6", 0, 0);
    wr(1, 32'h7858_0500);
    do_read(13'h100, 6, "R10 mid-access change", 3, 32'h7858_0000);
    do_read(13'h101, 1, "R10 new value next read", 0, 0);
    wr(0, 32'h0);
    rb(0, 32'h0, "R6 exit on zero");
    wr(1, 32'h7858_0400);
    rb(1, 32'h000, "R8 after exit ignored");
    wr(0, 32'h81); wr(0, 32'h55); wr(0, 32'h28);
    rb(0, 32'h0, "R5 broken pair");
    wr(0, 32'h28);
    rb(0, 32'h0, "R5 lone second code");
    wr(0, 32'h81); wr(0, 32'h81); wr(0, 32'h28);
    rb(0, 32'h1, "R4 repeated first code");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule